// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block decides which of seven interrupt requests a small 8-bit core should take next. Software sets a master enable, one enable bit per source, and a two-bit level per source. Each level is split across two registers: one holds the upper bit of every source's level and the other holds the lower bit. On each cycle the arbiter picks one winner among the pending, enabled requests. It picks the highest level first and breaks ties with a fixed polling order. It then offers that winner to the core as a request plus a source index.

The block also tracks nesting. A 4-bit in-service mask holds one bit per level. The core's acknowledge sets the bit for the level it took. A return strobe retires the innermost handler. A pending request is offered only when its level is strictly above the level currently running. A level-3 handler therefore cannot be interrupted. Latching requests in the peripherals and fetching the vector are left to the surrounding logic.

Top module: `irq_nest_arbiter`

## Requirements
- R1: Reset clears the master enable, all source enables, both level registers and the in-service mask. After reset every register reads 0, `intReq` is 0 and `activeValid` is 0.
- R2: Register access.
  - Address 0 holds the master enable in bit 7 and the enable for source i in bit i (i = 0..6).
  - Address 1 holds the upper level bit for source i in bit i. Address 2 holds the lower level bit for source i in bit i.
  - Bit 7 of addresses 1 and 2 reads 0, and address 3 reads 0.
  - A write takes effect at the next clock edge. The read data follows `regAddr` in the same cycle.
- R3: While the master enable is 0, `intReq` stays 0 whatever the other enable bits and the requests are.
- R4: A source takes part in arbitration only while its own enable bit is 1 and its `irqReq` bit is 1.
- R5: A source's level is {upper bit, lower bit}, so 3 is the highest and 0 the lowest. Among the sources taking part, one at the highest level wins.
- R6: Among winners at the same level, the lowest source index wins. Sources are indexed: external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3, serial = 4, timer 2 = 5, other peripheral = 6.
- R7: `intReq` and `intSrc` follow `irqReq` in the same cycle, with no register in between. `intSrc` carries the index of the winner.
- R8: When `intAck` is 1 in a cycle where `intReq` is 1, the in-service bit for the winner's level is set at the next edge. `activeLevel` shows the highest set bit, and `activeValid` shows that the mask is non-empty.
- R9: While a handler runs, `intReq` is raised only if the winner's level is strictly above `activeLevel`.
- R10: While level 3 is in service, `intReq` stays 0.
- R11: `retiStrobe` clears only the highest set in-service bit at the next edge, so the next lower nested level resumes. If an acknowledge comes in the same cycle, the clear happens first and then the acknowledged level's bit is set.
- R12: `intAck` while `intReq` is 0 leaves the in-service mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for write and read |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr` |
| irqReq | input | 7 | Request lines, one per source index |
| intReq | output | 1 | Interrupt offered to the core |
| intSrc | output | 3 | Index of the offered source |
| intAck | input | 1 | Core takes the offered interrupt |
| retiStrobe | input | 1 | Return from the innermost handler |
| activeValid | output | 1 | At least one level in service |
| activeLevel | output | 2 | Highest level in service |

## Verification
`intReq`, `intSrc` and `regRdData` are combinational. They are due in the same cycle as the request lines or the address that drives them. The bench changes inputs at the falling edge and samples 1 ns later.

Register writes, acknowledges and returns act at the next rising edge. Their effect is checked at the following falling edge, one cycle after the stimulus. An arithmetic model in the bench, updated at the same edge, supplies every expected value. The bench steps through a directed sequence and then a long pseudo-random sweep of requests, writes, acknowledges and returns.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
  typedef logic [1:0] regAddr_t;
  localparam regAddr_t ADDR_ENABLE  = 2'd0;
  localparam regAddr_t ADDR_PRIO_HI = 2'd1;
  localparam regAddr_t ADDR_PRIO_LO = 2'd2;

  typedef struct packed {
    logic wrEnable;
    logic wrPrioHi;
    logic wrPrioLo;
    logic grant;
    logic retire;
  } ctlStrobes_t;
endpackage

// File: rtl/irq_nest_ctl.sv
module irq_nest_ctl
  import irq_nest_pkg::*;
(
  input  logic        regWrEn,
  input  regAddr_t    regAddr,
  input  logic        intAck,
  input  logic        hitValid,
  input  logic        retiStrobe,
  output ctlStrobes_t stb
);
  always_comb begin
    stb.wrEnable = regWrEn && (regAddr == ADDR_ENABLE);
    stb.wrPrioHi = regWrEn && (regAddr == ADDR_PRIO_HI);
    stb.wrPrioLo = regWrEn && (regAddr == ADDR_PRIO_LO);
    // only an offered request can be granted
    stb.grant    = intAck && hitValid;
    stb.retire   = retiStrobe;
  end
endmodule

// File: rtl/irq_nest_dp.sv
module irq_nest_dp
  import irq_nest_pkg::*;
#(
  parameter int NumSrc = 7,
  parameter int DataW  = 8,
  localparam int SrcW  = $clog2(NumSrc),
  localparam int LvlW  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic [DataW-1:0]  wrData,
  input  regAddr_t          rdAddr,
  input  logic [NumSrc-1:0] reqIn,
  output logic [DataW-1:0]  rdData,
  output logic              hitValid,
  output logic [SrcW-1:0]   hitSrc,
  output logic [LvlW-1:0]   hitLevel,
  output logic              runValid,
  output logic [LvlW-1:0]   runLevel,
  output logic              globalEn
);
  localparam int NumLvl = 1 << LvlW;

  logic [NumSrc-1:0] enReg, prioHi, prioLo;
  logic [NumLvl-1:0] inServ, inServNext, clrMask, setMask;
  logic              found;

  // winner: highest level, then lowest index (scan high index to low)
  always_comb begin
    found    = 1'b0;
    hitSrc   = '0;
    hitLevel = '0;
    for (int i = NumSrc - 1; i >= 0; i--) begin
      if (globalEn && enReg[i] && reqIn[i] &&
          (!found || {prioHi[i], prioLo[i]} >= hitLevel)) begin
        found    = 1'b1;
        hitSrc   = SrcW'(i);
        hitLevel = {prioHi[i], prioLo[i]};
      end
    end
  end

  // innermost running level is the highest set in-service bit
  always_comb begin
    runValid = 1'b0;
    runLevel = '0;
    clrMask  = '0;
    for (int l = 0; l < NumLvl; l++) begin
      if (inServ[l]) begin
        runValid = 1'b1;
        runLevel = LvlW'(l);
      end
    end
    if (stb.retire && runValid) clrMask[runLevel] = 1'b1;
  end

  assign hitValid = found && (!runValid || (hitLevel > runLevel));

  always_comb begin
    setMask = '0;
    if (stb.grant) setMask[hitLevel] = 1'b1;
    inServNext = (inServ & ~clrMask) | setMask;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      globalEn <= 1'b0;
      enReg    <= '0;
      prioHi   <= '0;
      prioLo   <= '0;
      inServ   <= '0;
    end else begin
      if (stb.wrEnable) begin
        globalEn <= wrData[DataW-1];
        enReg    <= wrData[NumSrc-1:0];
      end
      if (stb.wrPrioHi) prioHi <= wrData[NumSrc-1:0];
      if (stb.wrPrioLo) prioLo <= wrData[NumSrc-1:0];
      inServ <= inServNext;
    end
  end

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      ADDR_ENABLE: begin
        rdData[NumSrc-1:0] = enReg;
        rdData[DataW-1]    = globalEn;
      end
      ADDR_PRIO_HI: rdData[NumSrc-1:0] = prioHi;
      ADDR_PRIO_LO: rdData[NumSrc-1:0] = prioLo;
      default:      rdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
  import irq_nest_pkg::*;
#(
  parameter int NumSrc = 7,
  parameter int DataW  = 8,
  localparam int SrcW  = $clog2(NumSrc)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DataW-1:0]  regWrData,
  output logic [DataW-1:0]  regRdData,
  input  logic [NumSrc-1:0] irqReq,
  output logic              intReq,
  output logic [SrcW-1:0]   intSrc,
  input  logic              intAck,
  input  logic              retiStrobe,
  output logic              activeValid,
  output logic [1:0]        activeLevel
);
  ctlStrobes_t stb;
  logic [1:0]  winLevel;
  logic        globalEn;

  irq_nest_ctl u_ctl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .intAck    (intAck),
    .hitValid  (intReq),
    .retiStrobe(retiStrobe),
    .stb       (stb)
  );

  irq_nest_dp #(.NumSrc(NumSrc), .DataW(DataW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (regWrData),
    .rdAddr  (regAddr),
    .reqIn   (irqReq),
    .rdData  (regRdData),
    .hitValid(intReq),
    .hitSrc  (intSrc),
    .hitLevel(winLevel),
    .runValid(activeValid),
    .runLevel(activeLevel),
    .globalEn(globalEn)
  );
endmodule

// File: rtl/irq_nest_checker.sv
module irq_nest_checker #(
  parameter int NumSrc = 7,
  localparam int SrcW  = $clog2(NumSrc)
) (
  input logic            clk,
  input logic            rstN,
  input logic            intReq,
  input logic [SrcW-1:0] intSrc,
  input logic            intAck,
  input logic            retiStrobe,
  input logic            activeValid,
  input logic [1:0]      activeLevel,
  input logic [1:0]      winLevel,
  input logic            globalEn
);
  assert_master_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !intReq);

  assert_src_in_range_R6: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (int'(intSrc) < NumSrc));

  assert_ack_sets_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && intAck && !retiStrobe) |=> (activeValid && activeLevel == $past(winLevel)));

  assert_strictly_higher_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && activeValid) |-> (winLevel > activeLevel));

  assert_top_level_locked_R10: assert property (@(posedge clk) disable iff (!rstN)
    (activeValid && activeLevel == 2'd3) |-> !intReq);

  assert_reti_drops_level_R11: assert property (@(posedge clk) disable iff (!rstN)
    (retiStrobe && activeValid && !(intReq && intAck))
      |=> (!activeValid || activeLevel < $past(activeLevel)));

  assert_stray_ack_ignored_R12: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intReq && !retiStrobe) |=> ($stable(activeValid) && $stable(activeLevel)));
endmodule

bind irq_nest_arbiter irq_nest_checker #(.NumSrc(NumSrc)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .intReq     (intReq),
  .intSrc     (intSrc),
  .intAck     (intAck),
  .retiStrobe (retiStrobe),
  .activeValid(activeValid),
  .activeLevel(activeLevel),
  .winLevel   (winLevel),
  .globalEn   (globalEn)
);

// File: tb/irq_nest_arbiter_bench.sv
`timescale 1ns/1ps
module irq_nest_arbiter_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [6:0] irqReq = '0;
  logic       intReq;
  logic [2:0] intSrc;
  logic       intAck = 1'b0;
  logic       retiStrobe = 1'b0;
  logic       activeValid;
  logic [1:0] activeLevel;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  // reference model state
  bit       mG;
  bit [6:0] mEn, mHi, mLo;
  bit [3:0] mMask;
  int unsigned seed = 32'h1234_5678;

  always #2 clk = ~clk;

  irq_nest_arbiter u_irq_nest_arbiter (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqReq(irqReq),
    .intReq(intReq), .intSrc(intSrc), .intAck(intAck),
    .retiStrobe(retiStrobe), .activeValid(activeValid), .activeLevel(activeLevel)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int runLvl();
    int r = -1;
    for (int l = 0; l < 4; l++) if (mMask[l]) r = l;
    return r;
  endfunction

  function automatic int rdModel(bit [1:0] a);
    case (a)
      2'd0: return {mG, mEn};
      2'd1: return {1'b0, mHi};
      2'd2: return {1'b0, mLo};
      default: return 0;
    endcase
  endfunction

  // one cycle: drive at falling edge, check 1 ns later, clock, update model
  task automatic step(bit [6:0] req, bit ack, bit reti, bit we, bit [1:0] a,
                      bit [7:0] d, string tag);
    int best = -1;
    int src = 0;
    int run;
    bit expReq;
    @(negedge clk);
    irqReq = req; intAck = ack; retiStrobe = reti;
    regWrEn = we; regAddr = a; regWrData = d;
    #1;
    for (int l = 3; l >= 0; l--)
      for (int i = 0; i < 7; i++)
        if (best < 0 && mG && mEn[i] && req[i] && (int'({mHi[i], mLo[i]}) == l)) begin
          best = l; src = i;
        end
    run = runLvl();
    expReq = (best >= 0) && (best > run);
    check({tag, " intReq"}, int'(intReq), int'(expReq));
    if (expReq) check({tag, " intSrc"}, int'(intSrc), src);
    check({tag, " activeValid"}, int'(activeValid), int'(run >= 0));
    if (run >= 0) check({tag, " activeLevel"}, int'(activeLevel), run);
    check({tag, " regRdData"}, int'(regRdData), rdModel(a));
    @(posedge clk);
    if (we) begin
      case (a)
        2'd0: begin mG = d[7]; mEn = d[6:0]; end
        2'd1: mHi = d[6:0];
        2'd2: mLo = d[6:0];
        default: ;
      endcase
    end
    if (reti && run >= 0) mMask[run] = 1'b0;
    if (ack && expReq) mMask[best] = 1'b1;
  endtask

  function automatic int unsigned nextRand();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  initial begin
    mG = 0; mEn = 0; mHi = 0; mLo = 0; mMask = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // reset state
    step(7'h7F, 0, 0, 0, 2'd0, 8'h00, "R1");
    step(7'h7F, 0, 0, 0, 2'd1, 8'h00, "R1");
    step(7'h00, 0, 0, 0, 2'd2, 8'h00, "R1");
    // register map
    step(0, 0, 0, 1, 2'd0, 8'hA5, "R2");
    step(0, 0, 0, 0, 2'd0, 8'h00, "R2");
    step(0, 0, 0, 1, 2'd1, 8'hFF, "R2");
    step(0, 0, 0, 0, 2'd1, 8'h00, "R2");
    step(0, 0, 0, 0, 2'd3, 8'h00, "R2");
    step(0, 0, 0, 1, 2'd1, 8'h00, "R2");
    // master enable off
    step(0, 0, 0, 1, 2'd0, 8'h7F, "R3");
    step(7'h7F, 0, 0, 0, 2'd0, 8'h00, "R3");
    // per-source enable
    step(0, 0, 0, 1, 2'd0, 8'h84, "R4");
    step(7'h7F, 0, 0, 0, 2'd0, 8'h00, "R4");
    step(7'h7B, 0, 0, 0, 2'd0, 8'h00, "R4");
    // highest level wins
    step(0, 0, 0, 1, 2'd0, 8'hFF, "R5");
    step(0, 0, 0, 1, 2'd1, 8'h10, "R5");
    step(7'h7F, 0, 0, 0, 2'd1, 8'h00, "R5");
    // polling order inside a level
    step(0, 0, 0, 1, 2'd1, 8'h00, "R6");
    step(7'h68, 0, 0, 0, 2'd0, 8'h00, "R6");
    step(7'h40, 0, 0, 0, 2'd0, 8'h00, "R6");
    // same-cycle response
    step(7'h00, 0, 0, 0, 2'd0, 8'h00, "R7");
    step(7'h01, 0, 0, 0, 2'd0, 8'h00, "R7");
    // acknowledge nests level 2
    step(0, 0, 0, 1, 2'd1, 8'h30, "R8");
    step(7'h10, 1, 0, 0, 2'd0, 8'h00, "R8");
    step(7'h10, 0, 0, 0, 2'd0, 8'h00, "R9");
    step(0, 0, 0, 1, 2'd2, 8'h20, "R9");
    step(7'h30, 0, 0, 0, 2'd0, 8'h00, "R9");
    // level 3 locks out everything
    step(7'h30, 1, 0, 0, 2'd0, 8'h00, "R10");
    step(7'h7F, 0, 0, 0, 2'd0, 8'h00, "R10");
    // stray acknowledge
    step(7'h00, 1, 0, 0, 2'd0, 8'h00, "R12");
    step(7'h00, 0, 0, 0, 2'd0, 8'h00, "R12");
    // return drops one level
    step(7'h00, 0, 1, 0, 2'd0, 8'h00, "R11");
    step(7'h20, 0, 0, 0, 2'd0, 8'h00, "R11");
    step(7'h00, 0, 1, 0, 2'd0, 8'h00, "R11");
    step(7'h00, 0, 0, 0, 2'd0, 8'h00, "R11");
    // pseudo-random sweep against the model
    for (int n = 0; n < 4000; n++) begin
      int unsigned r = nextRand();
      bit we = (r[2:0] == 3'd0);
      step(7'(nextRand()), r[5:4] == 2'd0, r[8:6] == 3'd0, we,
           2'(r[10:9]), 8'(nextRand() | (r[11] ? 32'h80 : 32'h0)), "R5 R9 R11 sweep");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule